// File: doc/BRIEF.md
# Asynchronous Serial Port with Receive FIFO

This block is a full-duplex asynchronous serial port for a processor's register bus. Characters written by software are framed and shifted out on the transmit line. Characters arriving on the receive line are oversampled, checked and queued in a four-entry FIFO. Because of the FIFO, software can read several characters late without losing any.

A single baud generator drives both directions with a tick at sixteen times the bit rate. The generator has two modes. In the first, a small prescale field picks a fixed divide ratio of the system clock. In the second, a 16-bit reloadable down counter divides the system clock by a time constant that software writes as a low byte and a high byte.

Top module: `sio_port`

## Requirements
- R1: After reset, txd is high, the status register (address 4) reads 0x08, and the receive FIFO is empty. Status bit 0 is receive-data-full, bit 1 is overrun, bit 2 is parity error and bit 3 is transmit-holding-empty.
- R2: The transmitter sends a frame whose bits are each 16 ticks long, in this order: one low start bit, then 7 or 8 data bits LSB first, then an optional parity bit, then 1 or 2 high stop bits. Control register (address 0) bit 1 selects 8 data bits, bit 2 enables parity, bit 3 selects odd parity (even otherwise) and bit 4 selects two stop bits.
- R3: When control bit 5 is set, the tick period is TC+1 clock cycles, where TC = {address 3, address 2}, so one bit lasts 16*(TC+1) clocks.
- R4: When control bit 5 is clear, the tick period is 10 << (sel + 2*x64) clocks, where sel is prescale register (address 1) bits 1:0 and x64 is its bit 2. This gives 160 clocks per bit for the lowest setting and four times the ratio in x64 mode.
- R5: A write to data address 5 loads the transmit holding register only while status bit 3 is set. A write made while the holding register is full is ignored. Bit 3 is clear while a character waits to be sent.
- R6: Reception happens only while control bit 0 is set. A frame that arrives while the bit is clear stores nothing.
- R7: A low level on rxd starts a frame only if it is still low at the middle of the start bit, 8 ticks later. Shorter low pulses are rejected as noise. Each data bit is sampled at its midpoint.
- R8: Received characters are queued in arrival order, up to four. A read of address 5 returns the oldest character and removes it. Status bit 0 is set while the FIFO is non-empty.
- R9: A character that completes while the FIFO holds four entries is discarded, and it sets the overrun flag. The flag stays set until software writes 1 to status bit 1.
- R10: When parity is enabled, a received character whose parity bit is wrong is still stored, and it sets the parity-error flag. The flag stays set until software writes 1 to status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Register access strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idle high |

## Verification
Six character formats are looped from txd back to rxd. They cover 7 and 8 data bits, no parity, even and odd parity, one and two stop bits, and data patterns with alternating, clustered and single set bits. Sampling each transmitted bit at mid-bit separates an ordering or parity-polarity fault from a timing fault, while the looped receive path shows that mid-bit sampling and character extraction agree with the transmitter. Directed streams then exercise noise pulses, disabled reception, a five-character burst into the four-entry queue, a bad parity bit and back-to-back transmit writes. Start-bit widths are measured for two time constants and two fixed prescale settings; these measurements tell the generator's two modes, and the high and low bytes of the time constant, apart.

// File: rtl/sio_port.sv
module sio_port #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       we,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rxd,
  output logic       txd
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]  ctrl;
  logic [2:0]  psr;
  logic [15:0] tc;
  logic        wr, rd;
  assign wr = sel & we;
  assign rd = sel & ~we;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= '0; psr <= '0; tc <= '0;
    end else if (wr) begin
      case (addr)
        3'd0: ctrl <= wdata;
        3'd1: psr <= wdata[2:0];
        3'd2: tc[7:0] <= wdata;
        3'd3: tc[15:8] <= wdata;
        default: ;
      endcase
    end

  // baud tick generator
  logic [2:0]  sh;
  logic [15:0] fixed_per, reload, bcnt;
  logic        tick;
  assign sh        = {1'b0, psr[2], 1'b0} + {1'b0, psr[1:0]};
  assign fixed_per = 16'd10 << sh;
  assign reload    = ctrl[5] ? tc : fixed_per - 16'd1;
  assign tick      = (bcnt == 16'd0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0;
    else        bcnt <= tick ? reload : bcnt - 16'd1;

  // transmitter
  logic [7:0]  thr;
  logic        thr_full, tx_busy;
  logic [11:0] tsh, fr;
  logic [3:0]  tleft, tcnt, flen;
  logic        tpar, load;

  assign tpar = ctrl[3] ^ (^(ctrl[1] ? thr : {1'b0, thr[6:0]}));
  assign flen = 4'd1 + (ctrl[1] ? 4'd8 : 4'd7) + {3'b0, ctrl[2]} + (ctrl[4] ? 4'd2 : 4'd1);
  assign load = tick & ~tx_busy & thr_full;

  always_comb begin
    fr = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < 7 || ctrl[1]) fr[1+i] = thr[i];
    if (ctrl[2]) begin
      if (ctrl[1]) fr[9] = tpar;
      else         fr[8] = tpar;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      thr <= '0; thr_full <= 1'b0; tx_busy <= 1'b0;
      tsh <= '1; tleft <= '0; tcnt <= '0;
    end else begin
      if (wr && addr == 3'd5 && !thr_full) begin
        thr <= wdata;
        thr_full <= 1'b1;
      end
      if (load) begin
        tsh <= fr; tleft <= flen; tcnt <= '0;
        tx_busy <= 1'b1; thr_full <= 1'b0;
      end else if (tx_busy && tick) begin
        tcnt <= tcnt + 4'd1;
        if (tcnt == 4'd15) begin
          tsh <= {1'b1, tsh[11:1]};
          tleft <= tleft - 4'd1;
          if (tleft == 4'd1) tx_busy <= 1'b0;
        end
      end
    end

  assign txd = tx_busy ? tsh[0] : 1'b1;

  // receiver
  typedef enum logic [1:0] {R_IDLE, R_START, R_BITS, R_STOP} rstate_t;
  rstate_t    rstate;
  logic       rs1, rs2;
  logic [3:0] rcnt, ridx, nrx;
  logic [8:0] rsh, rsh_al;
  logic [7:0] rdat;
  logic       rpar, push;

  assign nrx    = (ctrl[1] ? 4'd8 : 4'd7) + {3'b0, ctrl[2]};
  assign rsh_al = rsh >> (4'd9 - nrx);
  assign rdat   = ctrl[1] ? rsh_al[7:0] : {1'b0, rsh_al[6:0]};
  assign rpar   = ctrl[1] ? rsh_al[8] : rsh_al[7];
  assign push   = ctrl[0] && rstate == R_STOP && tick && rcnt == 4'd15;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rs1 <= 1'b1; rs2 <= 1'b1;
      rstate <= R_IDLE; rcnt <= '0; ridx <= '0; rsh <= '0;
    end else begin
      rs1 <= rxd; rs2 <= rs1;
      if (!ctrl[0]) rstate <= R_IDLE;
      else if (tick) begin
        rcnt <= rcnt + 4'd1;
        case (rstate)
          R_IDLE: if (!rs2) begin rstate <= R_START; rcnt <= '0; end
          R_START: if (rcnt == 4'd7) begin
            rcnt <= '0; ridx <= '0;
            rstate <= rs2 ? R_IDLE : R_BITS;
          end
          R_BITS: if (rcnt == 4'd15) begin
            rsh <= {rs2, rsh[8:1]};
            ridx <= ridx + 4'd1;
            if (ridx == nrx - 4'd1) rstate <= R_STOP;
          end
          R_STOP: if (rcnt == 4'd15) rstate <= R_IDLE;
          default: rstate <= R_IDLE;
        endcase
      end
    end

  // receive FIFO and sticky flags
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] fcnt;
  logic          full, pop, push_ok, ovr, perr;
  assign full    = (fcnt == CW'(DEPTH));
  assign pop     = rd && addr == 3'd5 && fcnt != '0;
  assign push_ok = push && !full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; fcnt <= '0; ovr <= 1'b0; perr <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push_ok) begin
        mem[wp] <= rdat;
        wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      fcnt <= fcnt + CW'(push_ok) - CW'(pop);
      if (wr && addr == 3'd4 && wdata[1]) ovr <= 1'b0;
      if (wr && addr == 3'd4 && wdata[2]) perr <= 1'b0;
      if (push && full) ovr <= 1'b1;
      if (push && ctrl[2] && (rpar != (ctrl[3] ^ (^rdat)))) perr <= 1'b1;
    end

  always_comb
    case (addr)
      3'd0: rdata = ctrl;
      3'd1: rdata = {5'b0, psr};
      3'd2: rdata = tc[7:0];
      3'd3: rdata = tc[15:8];
      3'd4: rdata = {4'b0, ~thr_full, perr, ovr, fcnt != '0};
      3'd5: rdata = mem[rp];
      default: rdata = '0;
    endcase
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel,
  input logic          we,
  input logic [2:0]    addr,
  input logic          clr_ovr,
  input logic          txd,
  input logic          tx_busy,
  input logic          thr_full,
  input logic          ovr,
  input logic          rx_en,
  input logic          rx_act,
  input logic [CW-1:0] fcnt
);
  a_r2_txd_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
  a_r5_thr_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && we && addr == 3'd5 && !thr_full) |=> thr_full);
  a_r6_rx_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_act);
  a_r8_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= CW'(DEPTH));
  a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !(sel && we && addr == 3'd4 && clr_ovr)) |=> ovr);
endmodule

bind sio_port sio_port_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .addr(addr),
  .clr_ovr(wdata[1]), .txd(txd), .tx_busy(tx_busy), .thr_full(thr_full),
  .ovr(ovr), .rx_en(ctrl[0]), .rx_act(rstate != R_IDLE), .fcnt(fcnt)
);

// File: tb/tb_sio_port.sv
module tb_sio_port;
  localparam int CLK_P = 10;
  localparam int NV = 6;
  // {control value, data byte}
  localparam logic [15:0] VEC [NV] = '{
    16'h23A5, 16'h215A, 16'h273C, 16'h2F3D, 16'h357F, 16'h3B80 };

  logic clk = 0, rst_n = 0, sel = 0, we = 0, loop = 0, rx_drv = 1;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic rxd, txd;
  int checks = 0, failures = 0;

  assign rxd = loop ? txd : rx_drv;
  always #(CLK_P/2) clk = ~clk;

  sio_port dut (.clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [7:0] d);
    sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; we = 0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [7:0] d);
    sel = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 0;
  endtask

  task automatic send_rx(logic [11:0] fr, int n);
    for (int i = 0; i < n; i++) begin
      rx_drv = fr[i];
      repeat (16) @(negedge clk);
    end
    rx_drv = 1;
    repeat (16) @(negedge clk);
  endtask

  task automatic start_width(logic [7:0] d, output int w);
    wr_reg(3'd5, d);
    while (txd !== 1'b0) @(negedge clk);
    w = 0;
    while (txd === 1'b0) begin w++; @(negedge clk); end
  endtask

  initial begin
    #(CLK_P * 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v, ctl, d, ed;
    logic [11:0] ef;
    int n, nd, w;
    logic bad;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txd idle", txd, 1);
    rd_reg(3'd4, v); chk("R1 status", v, 8'h08);

    // R2 R6 R8 formats via loopback, tc=0 gives 16 clocks per bit
    loop = 1;
    for (int k = 0; k < NV; k++) begin
      ctl = VEC[k][15:8]; d = VEC[k][7:0];
      nd = ctl[1] ? 8 : 7;
      ed = ctl[1] ? d : {1'b0, d[6:0]};
      ef = '1; ef[0] = 0;
      for (int i = 0; i < nd; i++) ef[1+i] = d[i];
      if (ctl[2]) ef[1+nd] = ctl[3] ^ (^ed);
      n = 1 + nd + ctl[2] + (ctl[4] ? 2 : 1);
      wr_reg(3'd0, ctl);
      wr_reg(3'd5, d);
      while (txd !== 1'b0) @(negedge clk);
      repeat (7) @(negedge clk);
      bad = 0;
      for (int i = 0; i < n; i++) begin
        if (i > 0) repeat (16) @(negedge clk);
        if (txd !== ef[i]) bad = 1;
      end
      chk("R2 transmitted frame bits", bad, 0);
      repeat (20) @(negedge clk);
      rd_reg(3'd4, v); chk("R8 rx full after frame", v[2:0], 3'b001);
      rd_reg(3'd5, v); chk("R8 loopback data", v, ed);
      rd_reg(3'd4, v); chk("R8 rx empty after pop", v[0], 0);
    end

    // R5 holding register: second back-to-back write and write while busy dropped
    wr_reg(3'd0, 8'h23);
    wr_reg(3'd5, 8'h11);
    wr_reg(3'd5, 8'h22);
    wr_reg(3'd5, 8'h33);
    rd_reg(3'd4, v); chk("R5 holding full", v[3], 0);
    wr_reg(3'd5, 8'h44);
    repeat (400) @(negedge clk);
    rd_reg(3'd5, v); chk("R5 first char", v, 8'h11);
    rd_reg(3'd5, v); chk("R5 second char", v, 8'h33);
    rd_reg(3'd4, v); chk("R5 no extra char", v[3:0], 4'b1000);
    loop = 0;

    // R7 noise rejection, then mid-bit reception
    rx_drv = 0; repeat (4) @(negedge clk); rx_drv = 1;
    repeat (300) @(negedge clk);
    rd_reg(3'd4, v); chk("R7 short low pulse ignored", v[0], 0);
    send_rx({2'b11, 8'h96, 1'b0}, 11);
    rd_reg(3'd5, v); chk("R7 mid-bit sampled data", v, 8'h96);

    // R6 reception disabled
    wr_reg(3'd0, 8'h22);
    send_rx({2'b11, 8'hC3, 1'b0}, 11);
    rd_reg(3'd4, v); chk("R6 nothing stored while disabled", v[0], 0);
    wr_reg(3'd0, 8'h23);

    // R9 overrun
    for (int i = 1; i <= 5; i++) send_rx({2'b11, 8'(i), 1'b0}, 11);
    rd_reg(3'd4, v); chk("R9 overrun set", v[1:0], 2'b11);
    for (int i = 1; i <= 4; i++) begin
      rd_reg(3'd5, v); chk("R8 FIFO order", v, i);
    end
    rd_reg(3'd4, v); chk("R9 sticky with empty FIFO", v[1:0], 2'b10);
    wr_reg(3'd4, 8'h02);
    rd_reg(3'd4, v); chk("R9 overrun cleared", v[1], 0);

    // R10 parity error, 8 bits even parity, wrong parity bit sent
    wr_reg(3'd0, 8'h27);
    send_rx({1'b1, ~(^8'h5B), 8'h5B, 1'b0}, 11);
    rd_reg(3'd4, v); chk("R10 parity error set", v[2], 1);
    rd_reg(3'd5, v); chk("R10 char still stored", v, 8'h5B);
    wr_reg(3'd4, 8'h04);
    rd_reg(3'd4, v); chk("R10 parity error cleared", v[2], 0);

    // R3 time-constant mode
    wr_reg(3'd0, 8'h22);
    wr_reg(3'd2, 8'h02);
    start_width(8'h01, w); chk("R3 bit width tc=2", w, 48);
    repeat (600) @(negedge clk);
    wr_reg(3'd3, 8'h01);
    start_width(8'h01, w); chk("R3 bit width tc=0x0102", w, 4144);
    repeat (45000) @(negedge clk);

    // R4 fixed prescale mode
    wr_reg(3'd0, 8'h02);
    wr_reg(3'd1, 8'h00);
    start_width(8'h01, w); chk("R4 bit width lowest ratio", w, 160);
    repeat (1800) @(negedge clk);
    wr_reg(3'd1, 8'h05);
    start_width(8'h01, w); chk("R4 bit width x64 sel1", w, 1280);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule